// File: doc/BRIEF.md
# Burst Beat Address and Lane Mask Generator

This block walks through the beats of one memory-bus burst. A command gives a start byte address, a beat-size code, a length field and a burst kind. The block latches the command and then presents the byte address of the current beat. It moves to the next beat each time the consumer pulses `advance`. It marks the final beat and drives the byte lanes of a `DATA_BYTES`-wide data bus that the current beat occupies.

Three burst kinds are supported. A fixed burst stays on one address for every beat, which suits a FIFO-style target. An incrementing burst climbs by the beat size. A wrapping burst climbs inside a power-of-two container and jumps back to the container base when it reaches the container's upper end, which is the usual pattern for cache-line fills. A start address need not be aligned. Only the first beat keeps the offset, and every later beat sits on a beat-size boundary. The block also flags an incrementing burst that runs into the next 4 KB page and a wrapping command whose shape is illegal. The block does not stop either burst. It only reports it.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `busy`, `last_beat`, `cross_4k`, `wrap_err` and `lane_mask` are all 0.
- R2: A `start` pulse while idle loads the command. From the next cycle `busy` is 1 and `beat_addr` equals `start_addr` unchanged, including any unaligned low bits, for beat 0.
- R3: With `start_kind` = 0 (fixed), every beat of the burst shows the start address.
- R4: With `start_kind` = 1 (incrementing), beat i for i ≥ 1 is the start address rounded down to the beat size, plus i times the beat size.
- R5: With `start_kind` = 2 (wrapping), the container is beat size × beat count bytes, and its base is the start address rounded down to the container size. Beat i for i ≥ 1 is base + ((rounded start − base + i × beat size) mod container).
- R6: `start_size` code s means 2^s bytes per beat, up to 128. `start_len` holds the beat count minus one, so 8 bits give up to 256 beats.
- R7: While busy, bit k of `lane_mask` is 1 exactly when lane k (0 to `DATA_BYTES`−1) is at or above `beat_addr` mod `DATA_BYTES` and falls in the same beat-size block of the bus. While idle, `lane_mask` is 0.
- R8: `last_beat` is 1 exactly when the current beat index equals `start_len`. An `advance` on the last beat makes `busy` 0 in the next cycle.
- R9: `cross_4k` is 1 during an incrementing burst whose last byte lies in a different 4096-byte page from the start address. The last byte is the rounded start plus beat count × beat size, minus 1. Fixed and wrapping bursts never raise the flag.
- R10: `wrap_err` is 1 during a wrapping burst whose start address is not a multiple of the beat size, or whose `start_len` is not 1, 3, 7 or 15.
- R11: `start` while busy is ignored. The burst, its address and its beat index carry on unchanged.
- R12: `advance` while idle is ignored. `busy` stays 0 and `beat_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new burst command (honoured only when idle) |
| start_addr | input | ADDR_W | First byte address |
| start_size | input | 3 | Beat size code, 2^code bytes |
| start_len | input | LEN_W | Beat count minus one |
| start_kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| advance | input | 1 | Consume the current beat |
| busy | output | 1 | A burst is in progress |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| lane_mask | output | DATA_BYTES | Byte lanes occupied by the current beat |
| last_beat | output | 1 | Current beat is the final one |
| cross_4k | output | 1 | Incrementing burst crosses a 4 KB page |
| wrap_err | output | 1 | Wrapping command has an illegal shape |

## Verification
The assertions assume three things about the inputs. The beat size never exceeds the data bus width. An incrementing burst never runs past the top of the address space. Kind code 3 is never issued. Every command in the stimulus uses size codes of at most 4 on a 16-byte bus and sits well below the address-space limit. The one wrapping command with an unaligned start keeps a power-of-two beat count, so its container is still well formed while the error flag is checked.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    KIND_FIXED = 2'd0,
    KIND_INCR  = 2'd1,
    KIND_WRAP  = 2'd2
  } burst_kind_e;

  localparam int PAGE_BITS = 12;
endpackage

// File: rtl/burst_step.sv
module burst_step #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        kind,
  output logic [ADDR_W-1:0] nxt_addr
);
  import burst_pkg::*;

  function automatic logic [ADDR_W-1:0] unit_bytes(input logic [2:0] s);
    return ADDR_W'(1) << s;
  endfunction

  function automatic logic [ADDR_W-1:0] round_down(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] span);
    return a & ~(span - ADDR_W'(1));
  endfunction

  logic [ADDR_W-1:0] unit, stepped, box, box_base;

  always_comb begin
    unit     = unit_bytes(size);
    stepped  = round_down(cur_addr, unit) + unit;
    box      = (ADDR_W'(len) + ADDR_W'(1)) << size;
    box_base = round_down(cur_addr, box);
    case (burst_kind_e'(kind))
      KIND_INCR: nxt_addr = stepped;
      KIND_WRAP: nxt_addr = (stepped == box_base + box) ? box_base : stepped;
      default:   nxt_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/burst_lanes.sv
module burst_lanes #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16
) (
  input  logic                  active,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] mask
);
  localparam int LANE_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic [LANE_W:0] first_lane, span, block_lo, block_hi;

  always_comb begin
    first_lane = {1'b0, addr[LANE_W-1:0]};
    span       = (LANE_W+1)'(1) << size;
    block_lo   = first_lane & ~(span - (LANE_W+1)'(1));
    block_hi   = block_lo + span - (LANE_W+1)'(1);
  end

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    assign mask[k] = active
                  && ((LANE_W+1)'(k) >= first_lane)
                  && ((LANE_W+1)'(k) <= block_hi);
  end
endmodule

// File: rtl/burst_check.sv
module burst_check #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        kind,
  output logic              page_cross,
  output logic              wrap_bad
);
  import burst_pkg::*;

  function automatic logic [ADDR_W-1:0] final_byte(input logic [ADDR_W-1:0] a,
                                                   input logic [2:0] s,
                                                   input logic [LEN_W-1:0] n);
    logic [ADDR_W-1:0] unit;
    unit = ADDR_W'(1) << s;
    return (a & ~(unit - ADDR_W'(1)))
         + ((ADDR_W'(n) + ADDR_W'(1)) << s) - ADDR_W'(1);
  endfunction

  function automatic logic legal_wrap_len(input logic [LEN_W-1:0] n);
    return (n == LEN_W'(1)) || (n == LEN_W'(3)) || (n == LEN_W'(7)) || (n == LEN_W'(15));
  endfunction

  logic [ADDR_W-1:0] tail;
  logic              misaligned;

  always_comb begin
    tail       = final_byte(addr, size, len);
    misaligned = (addr & ((ADDR_W'(1) << size) - ADDR_W'(1))) != '0;
    page_cross = (burst_kind_e'(kind) == KIND_INCR)
              && (tail[ADDR_W-1:PAGE_BITS] != addr[ADDR_W-1:PAGE_BITS]);
    wrap_bad   = (burst_kind_e'(kind) == KIND_WRAP)
              && (misaligned || !legal_wrap_len(len));
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int LEN_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic [2:0]            start_size,
  input  logic [LEN_W-1:0]      start_len,
  input  logic [1:0]            start_kind,
  input  logic                  advance,
  output logic                  busy,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] lane_mask,
  output logic                  last_beat,
  output logic                  cross_4k,
  output logic                  wrap_err
);
  logic              busy_q, x4k_q, werr_q;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [2:0]        size_q;
  logic [1:0]        kind_q;
  logic              cmd_cross, cmd_wrap_bad;

  wire load_ev = start && !busy_q;
  wire step_ev = advance && busy_q;
  wire end_ev  = busy_q && (cnt_q == len_q);
  wire done_ev = step_ev && end_ev;

  burst_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
    .addr(start_addr), .size(start_size), .len(start_len), .kind(start_kind),
    .page_cross(cmd_cross), .wrap_bad(cmd_wrap_bad)
  );

  burst_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .cur_addr(addr_q), .size(size_q), .len(len_q), .kind(kind_q),
    .nxt_addr(nxt_addr)
  );

  burst_lanes #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_lanes (
    .active(busy_q), .addr(addr_q), .size(size_q), .mask(lane_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      x4k_q  <= 1'b0;
      werr_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      size_q <= '0;
      kind_q <= '0;
    end else if (load_ev) begin
      busy_q <= 1'b1;
      addr_q <= start_addr;
      cnt_q  <= '0;
      len_q  <= start_len;
      size_q <= start_size;
      kind_q <= start_kind;
      x4k_q  <= cmd_cross;
      werr_q <= cmd_wrap_bad;
    end else if (done_ev) begin
      busy_q <= 1'b0;
    end else if (step_ev) begin
      addr_q <= nxt_addr;
      cnt_q  <= cnt_q + LEN_W'(1);
    end
  end

  assign busy      = busy_q;
  assign beat_addr = addr_q;
  assign last_beat = end_ev;
  assign cross_4k  = busy_q && x4k_q;
  assign wrap_err  = busy_q && werr_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int LEN_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  start,
  input logic                  advance,
  input logic [ADDR_W-1:0]     beat_addr,
  input logic [DATA_BYTES-1:0] lane_mask,
  input logic                  last_beat,
  input logic                  load_ev,
  input logic                  step_ev,
  input logic                  done_ev,
  input logic [LEN_W-1:0]      cnt_q,
  input logic [2:0]            size_q,
  input logic [1:0]            kind_q
);
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> busy && cnt_q == '0);

  a_r3_fixed_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev && !done_ev && kind_q == 2'd0 |=> beat_addr == $past(beat_addr));

  a_r4_incr_forward: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev && !done_ev && kind_q == 2'd1 |=> beat_addr > $past(beat_addr));

  a_r5_later_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_q != '0 && kind_q != 2'd0
      |-> (beat_addr & ((ADDR_W'(1) << size_q) - ADDR_W'(1))) == '0);

  a_r7_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lane_mask == '0);

  a_r7_busy_mask: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lane_mask != '0);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy && advance && last_beat |=> !busy);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !advance |=> busy && $stable(beat_addr) && $stable(cnt_q));

  a_r12_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && advance |=> !busy && $stable(beat_addr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .advance(advance),
  .beat_addr(beat_addr), .lane_mask(lane_mask), .last_beat(last_beat),
  .load_ev(load_ev), .step_ev(step_ev), .done_ev(done_ev),
  .cnt_q(cnt_q), .size_q(size_q), .kind_q(kind_q)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int DB = 16;
  localparam int LW = 8;

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  sz;
    logic [7:0]  len;
    logic [1:0]  kind;
    logic [31:0] fin;
    logic        x4k;
    logic        werr;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{32'h0000_1003, 3'd2, 8'd3,   2'd0, 32'h0000_1003, 1'b0, 1'b0},
    '{32'h0000_1003, 3'd2, 8'd3,   2'd1, 32'h0000_100C, 1'b0, 1'b0},
    '{32'h0000_0FF8, 3'd3, 8'd1,   2'd1, 32'h0000_1000, 1'b1, 1'b0},
    '{32'h0000_2038, 3'd3, 8'd3,   2'd2, 32'h0000_2030, 1'b0, 1'b0},
    '{32'h0000_0104, 3'd3, 8'd3,   2'd2, 32'h0000_0118, 1'b0, 1'b1},
    '{32'h0000_0000, 3'd4, 8'd255, 2'd1, 32'h0000_0FF0, 1'b0, 1'b0},
    '{32'h0000_0FFC, 3'd0, 8'd3,   2'd1, 32'h0000_0FFF, 1'b0, 1'b0},
    '{32'h0000_0FFD, 3'd0, 8'd3,   2'd1, 32'h0000_1000, 1'b1, 1'b0},
    '{32'h0000_0030, 3'd0, 8'd15,  2'd2, 32'h0000_003F, 1'b0, 1'b0},
    '{32'h0000_0034, 3'd2, 8'd1,   2'd2, 32'h0000_0030, 1'b0, 1'b0},
    '{32'h0000_0050, 3'd4, 8'd0,   2'd0, 32'h0000_0050, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    start_size = '0;
  logic [LW-1:0] start_len = '0;
  logic [1:0]    start_kind = '0;
  logic          advance = 1'b0;
  logic          busy, last_beat, cross_4k, wrap_err;
  logic [AW-1:0] beat_addr;
  logic [DB-1:0] lane_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(DB), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_size(start_size), .start_len(start_len), .start_kind(start_kind),
    .advance(advance), .busy(busy), .beat_addr(beat_addr), .lane_mask(lane_mask),
    .last_beat(last_beat), .cross_4k(cross_4k), .wrap_err(wrap_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input vec_t v, input int i);
    logic [31:0] unit, rounded, box, base;
    unit = 32'd1 << v.sz;
    if (v.kind == 2'd0 || i == 0) return v.addr;
    rounded = v.addr - (v.addr % unit);
    if (v.kind == 2'd1) return rounded + unit * 32'(i);
    box  = unit * (32'(v.len) + 32'd1);
    base = v.addr - (v.addr % box);
    return base + ((rounded - base + unit * 32'(i)) % box);
  endfunction

  function automatic logic [31:0] model_mask(input logic [31:0] a, input logic [2:0] sz);
    int lo, unit;
    logic [31:0] m;
    lo = int'(a % DB);
    unit = 1 << sz;
    m = '0;
    for (int k = 0; k < DB; k++)
      if (k >= lo && (k / unit) == (lo / unit)) m[k] = 1'b1;
    return m;
  endfunction

  function automatic string addr_req(input logic [1:0] kind);
    if (kind == 2'd0) return "R3";
    if (kind == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic run_burst(input vec_t v);
    logic [31:0] ea;
    @(negedge clk);
    start = 1'b1; start_addr = v.addr; start_size = v.sz;
    start_len = v.len; start_kind = v.kind;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after load", 32'(busy), 32'd1);
    check("R9", "cross_4k", 32'(cross_4k), 32'(v.x4k));
    check("R10", "wrap_err", 32'(wrap_err), 32'(v.werr));
    for (int i = 0; i <= int'(v.len); i++) begin
      ea = model_addr(v, i);
      if (i == 0) check("R2", "first beat address", beat_addr, v.addr);
      else check(addr_req(v.kind), "beat address", beat_addr, ea);
      check("R7", "lane mask", 32'(lane_mask), model_mask(ea, v.sz));
      check("R8", "last flag", 32'(last_beat), 32'(i == int'(v.len)));
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0;
    check("R8", "idle after last advance", 32'(busy), 32'd0);
    check("R6", "final beat address for size and length", beat_addr, v.fin);
    check("R7", "idle mask", 32'(lane_mask), 32'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy", 32'(busy), 32'd0);
    check("R1", "last", 32'(last_beat), 32'd0);
    check("R1", "mask", 32'(lane_mask), 32'd0);
    check("R1", "flags", {30'd0, cross_4k, wrap_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[n]) run_burst(VECS[n]);

    // R12: advance while idle does nothing
    advance = 1'b1;
    @(negedge clk);
    @(negedge clk);
    advance = 1'b0;
    check("R12", "busy stays low", 32'(busy), 32'd0);
    check("R12", "address held", beat_addr, 32'h0000_0050);

    // R11: start during a burst is ignored
    start = 1'b1; start_addr = 32'h0000_0100; start_size = 3'd2;
    start_len = 8'd3; start_kind = 2'd1;
    @(negedge clk);
    start = 1'b0;
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R4", "second beat", beat_addr, 32'h0000_0104);
    start = 1'b1; start_addr = 32'h0000_0900; start_len = 8'd0; start_kind = 2'd0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R11", "address unchanged", beat_addr, 32'h0000_0104);
    check("R11", "still busy", 32'(busy), 32'd1);
    check("R11", "not last", 32'(last_beat), 32'd0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check("R11", "original burst continues", beat_addr, 32'h0000_0108);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule